// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block sits on a simple synchronous host I/O bus and answers at two adjacent addresses. The lower address is the index port: the host writes a register number there. The upper address is the data port: the host reads or writes the chosen register through it. The port stays closed after reset. A single key byte written to the index port opens it, and a different key byte closes it again. While the port is closed, the data port behaves as if nothing is there.

Once the port is open, the host can choose a logical device number, read a fixed chip identifier, and read or write three per-device registers: an activate flag and the two bytes of a 16-bit base address. The address is stored low byte at the lower index, which is the reverse of the order many similar ports use. The per-device registers are banked, so each logical device keeps its own copy. The copy that belongs to the embedded-controller device is always driven out of the block as a decoded base address and an enable. Other logic in the chip uses these outputs to place that device's register window.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is closed, `bus_rdata` is 0xFF, the selected device number and every per-device register are zero, and `ec_base`/`ec_enable` are zero.
- R2: Writing 0x55 to the index port (address BASE_ADDR) while closed opens the port. Writing 0xAA to the index port while open closes it. Both take effect for the next bus access.
- R3: While the port is closed, data-port (BASE_ADDR+1) reads return 0xFF and data-port writes change no register.
- R4: While the port is closed, index-port writes other than 0x55 leave the latched index unchanged. While open, every index-port write other than 0xAA latches the byte as the index. A read of the index port returns the latched index when open and 0xFF when closed.
- R5: Index 0x20 reads CHIP_ID. Writes to it have no effect.
- R6: Index 0x07 is a read/write 8-bit logical device number shared by all devices. It selects the bank used by indexes 0x30, 0x66 and 0x67.
- R7: Index 0x30 bit 0 is the selected device's activate flag. Bits 7:1 read as zero. Each device keeps its own flag.
- R8: Index 0x66 holds the selected device's base-address low byte and index 0x67 its high byte. `ec_base` = {high, low} and `ec_enable` = activate flag of device EC_LDN (0x0C). Both reflect a write at the clock edge that accepts it.
- R9: `bus_rdata` is loaded at the clock edge that samples `bus_rd`. An unused index reads 0x00. With a device number of NUM_LDEV or more, the banked indexes read 0x00 and writes to them are ignored.
- R10: Accesses to any address other than BASE_ADDR and BASE_ADDR+1 change neither the port state nor `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ec_base | output | 16 | Base address of the embedded-controller device |
| ec_enable | output | 1 | Activate flag of the embedded-controller device |

## Verification
Every result is due one clock edge after its strobe. A read strobe presented at a falling edge is sampled at the next rising edge, and `bus_rdata` holds its answer at the falling edge after that. A write changes the lock state, index, device number or the `ec_base`/`ec_enable` outputs at that same rising edge. The bench drives each strobe for exactly one cycle between falling edges and samples only at the following falling edge. Its model is updated at that point, so each comparison sees the state just after the accepting edge and never a value in mid-change.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN    = 8'h55;
  localparam logic [7:0] KEY_CLOSE   = 8'hAA;
  localparam logic [7:0] IDX_DEVNUM  = 8'h07;
  localparam logic [7:0] IDX_CHIPID  = 8'h20;
  localparam logic [7:0] IDX_ACTIVE  = 8'h30;
  localparam logic [7:0] IDX_BASE_LO = 8'h66;
  localparam logic [7:0] IDX_BASE_HI = 8'h67;
  localparam logic [7:0] FLOAT_BYTE  = 8'hFF;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DEVNUM, SEL_CHIPID, SEL_ACTIVE, SEL_BLO, SEL_BHI
  } reg_sel_e;

  function automatic reg_sel_e decode_index(input logic [7:0] idx);
    case (idx)
      IDX_DEVNUM:  return SEL_DEVNUM;
      IDX_CHIPID:  return SEL_CHIPID;
      IDX_ACTIVE:  return SEL_ACTIVE;
      IDX_BASE_LO: return SEL_BLO;
      IDX_BASE_HI: return SEL_BHI;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_gate.sv
module sio_key_gate
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_q,
  output logic       idx_load
);
  always_comb idx_load = idx_wr && open_q && (wdata != KEY_CLOSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
    end else if (idx_wr) begin
      if (!open_q && wdata == KEY_OPEN)       open_q <= 1'b1;
      else if (open_q && wdata == KEY_CLOSE)  open_q <= 1'b0;
    end
  end

  // R2
  open_key_chk: assert property (@(posedge clk) disable iff (rst)
    (!open_q && idx_wr && wdata == KEY_OPEN) |=> open_q);
  // R2
  close_key_chk: assert property (@(posedge clk) disable iff (rst)
    (open_q && idx_wr && wdata == KEY_CLOSE) |=> !open_q);
  // R4
  stay_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (!open_q && !(idx_wr && wdata == KEY_OPEN)) |=> !open_q);
endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LDEV = 16,
  parameter int EC_LDN   = 12,
  localparam int LDN_W   = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [LDN_W-1:0] ldn,
  input  logic [7:0]       wdata,
  output logic             rd_act,
  output logic [7:0]       rd_lo,
  output logic [7:0]       rd_hi,
  output logic             ec_act,
  output logic [15:0]      ec_base
);
  localparam logic [LDN_W-1:0] EC_SEL = LDN_W'(EC_LDN);

  logic [NUM_LDEV-1:0]      act_q;
  logic [NUM_LDEV-1:0][7:0] lo_q;
  logic [NUM_LDEV-1:0][7:0] hi_q;
  logic [NUM_LDEV-1:0]      dev_we;

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_we
    assign dev_we[g] = wr_en && (ldn == LDN_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_LDEV; i++) begin
        if (dev_we[i]) begin
          case (wr_sel)
            SEL_ACTIVE: act_q[i] <= wdata[0];
            SEL_BLO:    lo_q[i]  <= wdata;
            SEL_BHI:    hi_q[i]  <= wdata;
            default:    ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_act  = act_q[ldn];
    rd_lo   = lo_q[ldn];
    rd_hi   = hi_q[ldn];
    ec_act  = act_q[EC_SEL];
    ec_base = {hi_q[EC_SEL], lo_q[EC_SEL]};
  end

  // R8
  ec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && ldn == EC_SEL) |=> ($stable(ec_base) && $stable(ec_act)));
  // R8
  ec_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ldn == EC_SEL && wr_sel == SEL_BLO) |=> ec_base[7:0] == $past(wdata));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004E,
  parameter int              NUM_LDEV  = 16,
  parameter int              EC_LDN    = 12,
  parameter logic [7:0]      CHIP_ID   = 8'hC6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [15:0]       ec_base,
  output logic              ec_enable
);
  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  logic       idx_hit, dat_hit, open_q, idx_load;
  logic [7:0] index_q, devnum_q, rd_val;
  logic       dev_ok, bank_act;
  logic [7:0] bank_lo, bank_hi;
  reg_sel_e   sel;

  always_comb begin
    idx_hit = (bus_addr == BASE_ADDR);
    dat_hit = (bus_addr == DATA_ADDR);
    sel     = decode_index(index_q);
    dev_ok  = (int'(devnum_q) < NUM_LDEV);
  end

  sio_key_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (bus_wr && idx_hit),
    .wdata    (bus_wdata),
    .open_q   (open_q),
    .idx_load (idx_load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q  <= '0;
      devnum_q <= '0;
    end else begin
      if (idx_load) index_q <= bus_wdata;
      if (bus_wr && dat_hit && open_q && sel == SEL_DEVNUM) devnum_q <= bus_wdata;
    end
  end

  sio_ldev_bank #(.NUM_LDEV(NUM_LDEV), .EC_LDN(EC_LDN)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && dat_hit && open_q && dev_ok),
    .wr_sel  (sel),
    .ldn     (devnum_q[LDN_W-1:0]),
    .wdata   (bus_wdata),
    .rd_act  (bank_act),
    .rd_lo   (bank_lo),
    .rd_hi   (bank_hi),
    .ec_act  (ec_enable),
    .ec_base (ec_base)
  );

  always_comb begin
    rd_val = 8'h00;
    if (!open_q) begin
      rd_val = FLOAT_BYTE;
    end else if (idx_hit) begin
      rd_val = index_q;
    end else begin
      case (sel)
        SEL_DEVNUM: rd_val = devnum_q;
        SEL_CHIPID: rd_val = CHIP_ID;
        SEL_ACTIVE: rd_val = dev_ok ? {7'b0, bank_act} : 8'h00;
        SEL_BLO:    rd_val = dev_ok ? bank_lo : 8'h00;
        SEL_BHI:    rd_val = dev_ok ? bank_hi : 8'h00;
        default:    rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         bus_rdata <= FLOAT_BYTE;
    else if (bus_rd && (idx_hit || dat_hit)) bus_rdata <= rd_val;
  end

  // R3
  closed_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && dat_hit && !open_q) |=> bus_rdata == 8'hFF);
  // R5
  chip_id_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && dat_hit && open_q && index_q == IDX_CHIPID) |=> bus_rdata == CHIP_ID);
  // R4
  index_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !open_q |=> $stable(index_q));
  // R6
  devnum_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dat_hit && open_q && index_q == IDX_DEVNUM) |=> devnum_q == $past(bus_wdata));
  // R10
  offport_chk: assert property (@(posedge clk) disable iff (rst)
    !(idx_hit || dat_hit) |=> ($stable(bus_rdata) && $stable(open_q)));
endmodule

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;
  localparam logic [15:0] BASE = 16'h004E;
  localparam logic [15:0] DATA = 16'h004F;
  localparam logic [15:0] OFFP = 16'h002E;
  localparam logic [7:0]  CID  = 8'hC6;
  localparam int          NDEV = 16;
  localparam int          ECD  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] ec_base;
  logic        ec_enable;

  int n_run = 0, n_fail = 0;

  // model state
  logic       m_open;
  logic [7:0] m_idx, m_dev, m_rd;
  logic [7:0] m_lo [NDEV];
  logic [7:0] m_hi [NDEV];
  logic       m_act [NDEV];

  always #2.5 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ec_base(ec_base), .ec_enable(ec_enable)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic void model_reset();
    m_open = 1'b0; m_idx = 8'h00; m_dev = 8'h00; m_rd = 8'hFF;
    for (int i = 0; i < NDEV; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_act[i] = 0; end
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
    if (a == BASE) begin
      if (!m_open) m_open = (d == 8'h55);
      else if (d == 8'hAA) m_open = 1'b0;
      else m_idx = d;
    end else if (a == DATA && m_open) begin
      if (m_idx == 8'h07) m_dev = d;
      else if (int'(m_dev) < NDEV) begin
        if (m_idx == 8'h30) m_act[m_dev] = d[0];
        if (m_idx == 8'h66) m_lo[m_dev] = d;
        if (m_idx == 8'h67) m_hi[m_dev] = d;
      end
    end
  endfunction

  function automatic logic [7:0] model_read(input logic [15:0] a);
    logic ok;
    ok = int'(m_dev) < NDEV;
    if (a == BASE) return m_open ? m_idx : 8'hFF;
    if (a != DATA) return m_rd;
    if (!m_open) return 8'hFF;
    case (m_idx)
      8'h07: return m_dev;
      8'h20: return CID;
      8'h30: return ok ? {7'b0, m_act[m_dev]} : 8'h00;
      8'h66: return ok ? m_lo[m_dev] : 8'h00;
      8'h67: return ok ? m_hi[m_dev] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [15:0] a);
    if (a != BASE && a != DATA) return "R10";
    if (!m_open) return (a == BASE) ? "R4" : "R3";
    if (a == BASE) return "R4";
    case (m_idx)
      8'h07: return "R6";
      8'h20: return "R5";
      8'h30: return "R7";
      8'h66, 8'h67: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    model_write(a, d);
    chk("R8", ec_base, {m_hi[ECD], m_lo[ECD]});
    chk("R8", {15'b0, ec_enable}, {15'b0, m_act[ECD]});
  endtask

  task automatic rd(input logic [15:0] a);
    string r;
    logic [7:0] e;
    r = req_of(a);
    e = model_read(a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    m_rd = e;
    chk(r, {8'h0, bus_rdata}, {8'h0, e});
  endtask

  task automatic cfg(input logic [7:0] idx, input logic [7:0] d);
    wr(BASE, idx); wr(DATA, d);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", {8'h0, bus_rdata}, 16'h00FF);
    chk("R1", ec_base, 16'h0000);
    chk("R1", {15'b0, ec_enable}, 16'h0);
    rd(DATA);                          // R3 closed read
    // R3 / R4: closed writes ignored
    wr(BASE, 8'h07); wr(DATA, 8'h33); wr(BASE, 8'hAA);
    wr(BASE, 8'h55);                   // R2 open
    rd(BASE);                          // R4 index still 0
    cfg(8'h07, 8'h00); rd(DATA);       // R6
    // R8 program embedded-controller device
    cfg(8'h07, 8'h0C); rd(DATA);
    cfg(8'h30, 8'hFF); rd(DATA);       // R7 reads 0x01
    cfg(8'h66, 8'h34); cfg(8'h67, 8'h12); rd(DATA);
    chk("R8", ec_base, 16'h1234);
    // R5 chip id read-only
    cfg(8'h20, 8'h00); rd(DATA);
    // R7 banking: device 3 separate
    cfg(8'h07, 8'h03); cfg(8'h30, 8'h00); cfg(8'h66, 8'hA5); rd(DATA);
    chk("R7", {15'b0, ec_enable}, 16'h1);
    cfg(8'h07, 8'h0C); wr(BASE, 8'h66); rd(DATA);
    // R9 out-of-range device and unused index
    cfg(8'h07, 8'h20); cfg(8'h66, 8'h77); rd(DATA);
    wr(BASE, 8'h45); rd(DATA);
    // R2 close then data reads float
    wr(BASE, 8'hAA); rd(DATA); rd(BASE);
    // R10 off-port key does not open; off-port read keeps rdata
    wr(OFFP, 8'h55); rd(DATA); rd(OFFP);
    wr(OFFP + 16'h1, 8'h12);
    wr(BASE, 8'h55); rd(BASE);         // R2 reopen, R4 index kept
    // random mix
    for (int k = 0; k < 600; k++) begin
      int op;
      logic [7:0] pick;
      op = int'($urandom % 10);
      case ($urandom % 8)
        0: pick = 8'h07; 1: pick = 8'h20; 2: pick = 8'h30; 3: pick = 8'h66;
        4: pick = 8'h67; 5: pick = 8'h55; 6: pick = 8'hAA; default: pick = 8'($urandom);
      endcase
      if (op < 2) wr(BASE, pick);
      else if (op < 5) wr(DATA, (m_idx == 8'h07) ? 8'($urandom % 18) : 8'($urandom));
      else if (op < 8) rd(DATA);
      else if (op == 8) rd(BASE);
      else if ($urandom % 2 == 0) wr(OFFP + 16'($urandom % 2), pick);
      else rd(OFFP);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule